// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table that sits in ordinary memory. The caller hands over a virtual address together with the kind of access: a write or a read, made from user or supervisor mode. The walker first reads a directory entry. The first-level table holds the directory entries, and its location is given by a base frame number. The walker then reads the page-table entry that the directory entry points to. It returns the physical address, or a fault code if an entry is missing or the access is not permitted. Only one walk is in progress at a time, and a busy pin reports it.

The request and response sides are valid/ready streams:
- A request is taken in the cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the walker is idle.
- A response is offered with `rsp_valid`. It is held unchanged until the caller raises `rsp_ready`.
- While a response waits, the walker accepts no new request. Back-pressure on the response side therefore stalls the request side.

The memory side is a req/ack port with word addressing. The walker holds `mem_req` and `mem_addr` until `mem_ack` is seen, and it takes `mem_rdata` in that same cycle.

Entry layout, for both levels:
- bit 0: present
- bit 1: writable
- bit 2: user access allowed
- bits 31:12: frame number

The walker ignores every other bit.

Top module: `pt_walker`

## Requirements
- R1: A request is accepted only on a cycle with `req_valid` and `req_ready` both high. `req_ready` is high exactly when the walker is idle. `busy` is high from the cycle after acceptance until the response has been taken.
- R2: The first memory read goes to word address {base frame (20 bits, sampled at acceptance), vaddr[31:22]}.
- R3: The second memory read goes to word address {directory entry bits 31:12, vaddr[21:12]}.
- R4: Once `mem_req` is high, it stays high and `mem_addr` stays stable until a cycle with `mem_ack` high.
- R5: If the directory entry has bit 0 clear, the response code is 1 (directory miss), and exactly one memory read is made.
- R6: An access is permitted by an entry only under two conditions. A write access (`req_write`=1) needs bit 1 set. A user access (`req_user`=1) needs bit 2 set. If a present directory entry does not permit the access, the code is 3 (protection), and no second read is made.
- R7: If the directory entry permits the access but the table entry has bit 0 clear, the code is 2 (table miss), after exactly two reads.
- R8: If the table entry is present but does not permit the access, the code is 3. The presence check is made before the permission check at each level.
- R9: A walk that passes both levels returns code 0, and `rsp_paddr` is {table entry bits 31:12, vaddr[11:0]}. Every fault returns `rsp_paddr` = 0.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the code and the address hold, and `req_ready` stays low.
- R11: After reset, `req_ready`=1, `busy`=0, `rsp_valid`=0 and `mem_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_base | input | 20 | Frame number of the first-level table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made from user mode |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Caller takes the response |
| rsp_code | output | 2 | 0 ok, 1 directory miss, 2 table miss, 3 protection |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| busy | output | 1 | A walk or an untaken response is in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 30 | Word address of the entry to read |
| mem_ack | input | 1 | Memory returns data this cycle |
| mem_rdata | input | 32 | Entry read from memory |

## Verification
The assertions watch the protocol on every cycle:
- the memory request and address hold until acknowledged;
- a pending response stays frozen under back-pressure;
- `busy` excludes request acceptance;
- no memory read is issued while a response waits;
- a fault never carries a nonzero address.

Only the bench's scenarios show the rest:
- which code comes out, and after how many reads;
- whether both read addresses are formed correctly;
- how the two levels' flags combine.

The bench sweeps every combination of directory flags, table flags and access type, with varied memory latency.

// File: rtl/pw_pkg.sv
package pw_pkg;

  typedef enum logic [1:0] {
    RSP_OK       = 2'd0,
    RSP_DIR_MISS = 2'd1,
    RSP_TBL_MISS = 2'd2,
    RSP_PROT     = 2'd3
  } rsp_code_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIR  = 2'd1,
    ST_TBL  = 2'd2,
    ST_RESP = 2'd3
  } walk_state_e;

  typedef struct packed {
    logic wr;
    logic usr;
  } access_t;

  localparam int unsigned FLAG_PRESENT = 0;
  localparam int unsigned FLAG_WRITE   = 1;
  localparam int unsigned FLAG_USER    = 2;
  localparam int unsigned FLAG_W       = 3;

endpackage

// File: rtl/pw_entry_check.sv
// Judges one fetched entry against the access being made.
module pw_entry_check
  import pw_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  access_t           acc,
  output logic              present,
  output logic              allowed
);

  always_comb begin
    present = flags[FLAG_PRESENT];
    allowed = (!acc.wr  || flags[FLAG_WRITE]) &&
              (!acc.usr || flags[FLAG_USER]);
  end

endmodule

// File: rtl/pw_addr_sel.sv
// Forms the word address of the entry for the current level.
module pw_addr_sel #(
  parameter int unsigned FRAME_W = 20,
  parameter int unsigned IDX_W   = 10
) (
  input  logic                     sel_tbl,
  input  logic [FRAME_W-1:0]       base_frame,
  input  logic [FRAME_W-1:0]       dir_frame,
  input  logic [IDX_W-1:0]         dir_idx,
  input  logic [IDX_W-1:0]         tbl_idx,
  output logic [FRAME_W+IDX_W-1:0] word_addr
);

  always_comb begin
    if (sel_tbl) word_addr = {dir_frame, tbl_idx};
    else         word_addr = {base_frame, dir_idx};
  end

endmodule

// File: rtl/pw_ctrl.sv
// Walk sequencer: accepts a request, issues the two reads, classifies.
module pw_ctrl
  import pw_pkg::*;
#(
  parameter int unsigned FRAME_W = 20,
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned OFF_W   = 12,
  localparam int unsigned VA_W   = 2*IDX_W + OFF_W,
  localparam int unsigned PA_W   = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  access_t            req_acc,
  input  logic [FRAME_W-1:0] base_in,
  input  logic               mem_ack,
  input  logic [FRAME_W-1:0] mem_frame,
  input  logic               ent_present,
  input  logic               ent_allowed,
  output logic               mem_req,
  output logic               sel_tbl,
  output logic [VA_W-1:0]    va_q,
  output access_t            acc_q,
  output logic [FRAME_W-1:0] base_q,
  output logic [FRAME_W-1:0] dir_frame_q,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output rsp_code_e          rsp_code,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               busy
);

  walk_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      va_q        <= '0;
      acc_q       <= '0;
      base_q      <= '0;
      dir_frame_q <= '0;
      rsp_code    <= RSP_OK;
      rsp_paddr   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q   <= req_vaddr;
            acc_q  <= req_acc;
            base_q <= base_in;
            state  <= ST_DIR;
          end
        end
        ST_DIR: begin
          if (mem_ack) begin
            if (!ent_present) begin
              rsp_code  <= RSP_DIR_MISS;
              rsp_paddr <= '0;
              state     <= ST_RESP;
            end else if (!ent_allowed) begin
              rsp_code  <= RSP_PROT;
              rsp_paddr <= '0;
              state     <= ST_RESP;
            end else begin
              dir_frame_q <= mem_frame;
              state       <= ST_TBL;
            end
          end
        end
        ST_TBL: begin
          if (mem_ack) begin
            state <= ST_RESP;
            if (!ent_present) begin
              rsp_code  <= RSP_TBL_MISS;
              rsp_paddr <= '0;
            end else if (!ent_allowed) begin
              rsp_code  <= RSP_PROT;
              rsp_paddr <= '0;
            end else begin
              rsp_code  <= RSP_OK;
              rsp_paddr <= {mem_frame, va_q[OFF_W-1:0]};
            end
          end
        end
        default: begin
          if (rsp_ready) state <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    req_ready = (state == ST_IDLE);
    busy      = (state != ST_IDLE);
    mem_req   = (state == ST_DIR) || (state == ST_TBL);
    sel_tbl   = (state == ST_TBL);
    rsp_valid = (state == ST_RESP);
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pw_pkg::*;
#(
  parameter int unsigned FRAME_W  = 20,
  parameter int unsigned IDX_W    = 10,
  parameter int unsigned OFF_W    = 12,
  localparam int unsigned VA_W    = 2*IDX_W + OFF_W,
  localparam int unsigned PA_W    = FRAME_W + OFF_W,
  localparam int unsigned ENTRY_W = FRAME_W + OFF_W,
  localparam int unsigned WORD_AW = FRAME_W + IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] tbl_base,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_write,
  input  logic               req_user,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [1:0]         rsp_code,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               busy,
  output logic               mem_req,
  output logic [WORD_AW-1:0] mem_addr,
  input  logic               mem_ack,
  input  logic [ENTRY_W-1:0] mem_rdata
);

  access_t            req_acc, acc_q;
  logic               ent_present, ent_allowed, sel_tbl;
  logic [VA_W-1:0]    va_q;
  logic [FRAME_W-1:0] base_q, dir_frame_q;
  rsp_code_e          code_q;
  logic               unused_bits;

  assign req_acc     = '{wr: req_write, usr: req_user};
  assign rsp_code    = code_q;
  assign unused_bits = ^mem_rdata[OFF_W-1:FLAG_W];

  pw_entry_check u_check (
    .flags   (mem_rdata[FLAG_W-1:0]),
    .acc     (acc_q),
    .present (ent_present),
    .allowed (ent_allowed)
  );

  pw_addr_sel #(.FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_addr (
    .sel_tbl    (sel_tbl),
    .base_frame (base_q),
    .dir_frame  (dir_frame_q),
    .dir_idx    (va_q[VA_W-1 -: IDX_W]),
    .tbl_idx    (va_q[OFF_W +: IDX_W]),
    .word_addr  (mem_addr)
  );

  pw_ctrl #(.FRAME_W(FRAME_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_vaddr   (req_vaddr),
    .req_acc     (req_acc),
    .base_in     (tbl_base),
    .mem_ack     (mem_ack),
    .mem_frame   (mem_rdata[ENTRY_W-1 -: FRAME_W]),
    .ent_present (ent_present),
    .ent_allowed (ent_allowed),
    .mem_req     (mem_req),
    .sel_tbl     (sel_tbl),
    .va_q        (va_q),
    .acc_q       (acc_q),
    .base_q      (base_q),
    .dir_frame_q (dir_frame_q),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_code    (code_q),
    .rsp_paddr   (rsp_paddr),
    .busy        (busy)
  );

endmodule

// File: rtl/pw_walker_chk.sv
module pw_walker_chk #(
  parameter int unsigned AW = 30,
  parameter int unsigned PW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [1:0]    rsp_code,
  input logic [PW-1:0] rsp_paddr
);

  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code) && $stable(rsp_paddr)));

  // R1
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R10
  rsp_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!req_ready && !mem_req));

  // R9
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != 2'd0) |-> (rsp_paddr == '0));

endmodule

bind pt_walker pw_walker_chk #(.AW(WORD_AW), .PW(PA_W)) u_walker_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .busy      (busy),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_code  (rsp_code),
  .rsp_paddr (rsp_paddr)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] tbl_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_paddr;
  logic        busy;
  logic        mem_req;
  logic [29:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
    .rsp_paddr(rsp_paddr), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] dir_ent, tbl_ent;
  logic [29:0] dir_wa, tbl_wa;
  int lat = 0;
  int wait_cnt = 0;
  int n_reads = 0;
  int n_bad_addr = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory responder: acks after lat idle cycles, returns entry by address.
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack  = 1'b0;
        wait_cnt = 0;
      end else if (mem_req) begin
        if (wait_cnt >= lat) begin
          mem_ack = 1'b1;
          n_reads++;
          if (mem_addr == dir_wa && n_reads == 1) mem_rdata = dir_ent;
          else if (mem_addr == tbl_wa && n_reads == 2) mem_rdata = tbl_ent;
          else begin
            n_bad_addr++;
            mem_rdata = 32'hFFFF_FFFF;
          end
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [19:0] base,
                      input logic [31:0] de, input logic [31:0] te,
                      input bit w, input bit u, input int hold);
    bit dp, dok, tp, tok;
    logic [1:0]  ecode;
    logic [31:0] epa;
    int ereads, bad0, k;
    bit got;
    dp  = de[0];
    dok = (!w || de[1]) && (!u || de[2]);
    tp  = te[0];
    tok = (!w || te[1]) && (!u || te[2]);
    if (!dp)       ecode = 2'd1;
    else if (!dok) ecode = 2'd3;
    else if (!tp)  ecode = 2'd2;
    else if (!tok) ecode = 2'd3;
    else           ecode = 2'd0;
    epa    = (ecode == 2'd0) ? {te[31:12], va[11:0]} : 32'h0;
    ereads = (!dp || !dok) ? 1 : 2;

    @(negedge clk);
    dir_ent = de; tbl_ent = te;
    dir_wa  = {base, va[31:22]};
    tbl_wa  = {de[31:12], va[21:12]};
    n_reads = 0; bad0 = n_bad_addr;
    tbl_base = base; req_vaddr = va; req_write = w; req_user = u;
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R1 ready when idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    tbl_base = ~base;
    req_vaddr = ~va;
    chk(busy == 1'b1 && req_ready == 1'b0, "R1 busy after accept", {busy, req_ready}, 2'b10);
    got = 0;
    for (k = 0; k < 40 && !got; k++) begin
      if (rsp_valid) got = 1;
      else @(negedge clk);
    end
    chk(got, "R1 response arrives", got, 1);
    case (ecode)
      2'd1: chk(rsp_code == ecode, "R5 directory miss code", rsp_code, ecode);
      2'd2: chk(rsp_code == ecode, "R7 table miss code", rsp_code, ecode);
      2'd3: chk(rsp_code == ecode, (ereads == 1) ? "R6 directory protection code" : "R8 table protection code", rsp_code, ecode);
      default: chk(rsp_code == ecode, "R9 ok code", rsp_code, ecode);
    endcase
    chk(rsp_paddr == epa, "R9 physical address", rsp_paddr, epa);
    chk(n_reads == ereads, (ereads == 1) ? "R5 R6 single read" : "R7 two reads", n_reads, ereads);
    chk(n_bad_addr == bad0, "R2 R3 entry addresses", n_bad_addr - bad0, 0);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && !req_ready && rsp_code == ecode && rsp_paddr == epa,
          "R10 held response", {rsp_valid, req_ready, rsp_code}, {1'b1, 1'b0, ecode});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && !busy && req_ready, "R1 idle after response taken",
        {rsp_valid, busy, req_ready}, 3'b001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11
    chk(req_ready && !busy && !rsp_valid && !mem_req, "R11 reset state",
        {req_ready, busy, rsp_valid, mem_req}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !busy && !rsp_valid && !mem_req, "R11 after reset release",
        {req_ready, busy, rsp_valid, mem_req}, 4'b1000);
    for (int df = 0; df < 8; df++) begin
      for (int tf = 0; tf < 8; tf++) begin
        for (int ac = 0; ac < 4; ac++) begin
          int idx;
          logic [31:0] va, de, te;
          logic [19:0] base, fd, ft;
          idx  = df*32 + tf*4 + ac;
          lat  = idx % 3;
          base = 20'h0ABCD + idx[19:0];
          fd   = 20'h01000 + idx[19:0]*20'd7;
          ft   = 20'h80000 ^ (idx[19:0]*20'd13);
          de   = {fd, 9'h0A0, df[2:0]};
          te   = {ft, 9'h048, tf[2:0]};
          va   = idx*32'h0040_3001 + 32'h1234_5ABC;
          walk(va, base, de, te, ac[0], ac[1], (idx % 5 == 0) ? 3 : 0);
        end
      end
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule